// File: doc/BRIEF.md
# Three-wire serial link transaction monitor

This block sits beside a three-wire serial memory link (chip select, serial clock, serial data in, serial data out) and listens without driving anything. All four lines are brought into the system clock domain and oversampled. Every interval in which chip select is high is a window. The monitor classifies each window as either a data transfer or a device status poll, and it emits one-cycle event strobes with timestamps from a free-running sample counter.

A window becomes a transfer when the data-in line is high at the first rising serial-clock edge. The first bit of a transfer is a start bit and has its own strobe. Every later clock period gives one data-in/data-out pair. Data-in is taken at the rising clock edge and data-out at the falling edge after it. The last pair is closed when chip select drops while the clock is low. A window with no clock edge, or with data-in low at the first edge, is a status poll. In a poll, data-out low means busy and high means ready. Each busy stretch is reported when data-out rises, and the level held when the window ends is reported as a final busy or ready interval.

Top module: `mw_monitor`

## Requirements
- R1: After reset no event is produced until chip select has been seen low. If chip select is already high when reset is released, that window is ignored in full.
- R2: In a transfer, each data pair is reported on `bit_valid`. `ev_si` is data-in at the rising clock edge that opened the bit and `ev_so` is data-out at the falling edge after it. `ev_end - ev_start` equals the number of system clocks from that rising edge to the next one.
- R3: When data-in is high at the first rising clock edge, the window is a transfer. Its first bit is reported once on `start_ok` with `ev_si`=1, never on `bit_valid`, when the second rising edge arrives. The stamps span rising edge to rising edge.
- R4: If data-in has gone low by the falling edge that follows the first rising edge of a transfer, the start bit is reported on `start_err` with `ev_si`=0 instead of `start_ok`.
- R5: A window with no clock edge is a poll. When chip select drops, the final interval is reported on `ready_done` if data-out is high or on `busy_done` if it is low. It spans from the last data-out change, or from the window start, to the drop.
- R6: When data-in is low at the first rising clock edge, the window is a poll and produces no `bit_valid`, `start_ok` or `start_err`.
- R7: During a poll, a low-to-high change of data-out produces `busy_done` spanning the preceding low interval. A high-to-low change produces no event but starts a new interval.
- R8: When chip select drops while the clock is low, the open data bit of a transfer is reported, ending at the drop. When the clock is high at the drop, the open bit is discarded.
- R9: At most one strobe is high in any cycle. Every event spans a nonzero number of counts. Each `bit_valid` starts at the count where the previous start or data event ended.
- R10: Once a window is a transfer, changes of data-out produce no `busy_done` or `ready_done`, and neither is produced when that window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_in | input | 1 | Chip select line, asynchronous |
| sk_in | input | 1 | Serial clock line, asynchronous |
| si_in | input | 1 | Data-in line (host to device), asynchronous |
| so_in | input | 1 | Data-out line (device to host), asynchronous |
| bit_valid | output | 1 | One-cycle strobe: data pair completed |
| start_ok | output | 1 | One-cycle strobe: start bit read high |
| start_err | output | 1 | One-cycle strobe: start bit read low |
| busy_done | output | 1 | One-cycle strobe: busy interval ended |
| ready_done | output | 1 | One-cycle strobe: ready interval ended |
| ev_si | output | 1 | Data-in value of the reported bit |
| ev_so | output | 1 | Data-out value of the reported bit or interval |
| ev_start | output | STAMP_W | Sample count at the event start |
| ev_end | output | STAMP_W | Sample count at the event end |

## Verification
The start-bit error is the hardest case to reach: data-in has to be high at the first rising clock edge, which makes the window a transfer, and then fall before the next falling edge. The bench gets there by dropping data-in a single system clock after that rising edge, so the change comes after the classifying sample and before the falling-edge sample. The ignored window at reset also needs care. Chip select is held high with clock activity across the release of reset, and the following correct transfer shows that the monitor waited for the line to go low.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
// mw_pkg: shared types and line indices for the serial link monitor.
// Assumes the four link lines are gathered into one vector in the order below.
package mw_pkg;
    localparam int LN_CS   = 0;
    localparam int LN_SK   = 1;
    localparam int LN_SI   = 2;
    localparam int LN_SO   = 3;
    localparam int N_LINES = 4;

    // Window handling phase.
    typedef enum logic [1:0] {
        PH_ARM  = 2'd0,   // after reset: wait for chip select low
        PH_IDLE = 2'd1,   // waiting for chip select high
        PH_OPEN = 2'd2    // inside a window
    } phase_t;

    // Window classification.
    typedef enum logic [1:0] {
        WK_UNDEC = 2'd0,  // no rising clock edge yet
        WK_XFER  = 2'd1,  // data transfer
        WK_POLL  = 2'd2   // status poll
    } kind_t;
endpackage

// File: rtl/mw_sync.sv
`timescale 1ns/1ps
// mw_sync: multi-stage synchronizer, one chain per line. It also produces a
// flag that goes high once the chains, plus the edge-history register after
// them, hold samples taken after reset.
// Assumes the lines are slow compared with clk, so a stable level is seen.
module mw_sync #(
    parameter int LINES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced,
    output logic             fill_ok
);
    localparam int FILL = STAGES + 1;

    logic [FILL-1:0] fill_q;

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            // Shift the raw line through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain_q[STAGES-1];
        end
    endgenerate

    // Count the fill of the chains with a shift of ones.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else        fill_q <= {fill_q[FILL-2:0], 1'b1};
    end

    assign fill_ok = fill_q[FILL-1];
endmodule

// File: rtl/mw_edge.sv
`timescale 1ns/1ps
// mw_edge: rising and falling edge detect on a synchronized line, found by
// comparing the present sample with the one from the previous cycle.
// Assumes the input is already in the clk domain.
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_q;

    // Keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/mw_stamp.sv
`timescale 1ns/1ps
// mw_stamp: free-running sample counter that supplies the event timestamps.
// It wraps at 2**W; only differences between stamps have meaning.
module mw_stamp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    // Advance once per system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/mw_core.sv
`timescale 1ns/1ps
// mw_core: window tracking, classification and event generation.
// Assumes synchronized levels, clock edge flags and a stamp all refer to the
// same cycle. Events come out registered, one cycle after detection, so every
// stamp has the same fixed latency.
module mw_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fill_ok,
    input  logic         s_cs,
    input  logic         s_sk,
    input  logic         s_si,
    input  logic         s_so,
    input  logic         sk_rise,
    input  logic         sk_fall,
    input  logic [W-1:0] now,
    output logic         o_bit,
    output logic         o_sok,
    output logic         o_serr,
    output logic         o_busy,
    output logic         o_ready,
    output logic         o_si,
    output logic         o_so,
    output logic [W-1:0] o_start,
    output logic [W-1:0] o_end
);
    import mw_pkg::*;

    phase_t       phase;
    kind_t        kind;
    logic         first_bit;  // start bit still open
    logic [W-1:0] b_start;    // stamp of the rising edge that opened the bit
    logic         b_si;
    logic         b_so;
    logic [W-1:0] iv_start;   // stamp of the last data-out change in a poll
    logic         iv_so;      // data-out level of the current poll interval

    // Window state machine and one-cycle event generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_ARM;
            kind      <= WK_UNDEC;
            first_bit <= 1'b0;
            b_start   <= '0;
            b_si      <= 1'b0;
            b_so      <= 1'b0;
            iv_start  <= '0;
            iv_so     <= 1'b0;
            o_bit     <= 1'b0;
            o_sok     <= 1'b0;
            o_serr    <= 1'b0;
            o_busy    <= 1'b0;
            o_ready   <= 1'b0;
            o_si      <= 1'b0;
            o_so      <= 1'b0;
            o_start   <= '0;
            o_end     <= '0;
        end else begin
            o_bit   <= 1'b0;
            o_sok   <= 1'b0;
            o_serr  <= 1'b0;
            o_busy  <= 1'b0;
            o_ready <= 1'b0;
            case (phase)
                PH_ARM: begin
                    if (fill_ok && !s_cs) phase <= PH_IDLE;
                end
                PH_IDLE: begin
                    if (s_cs) begin
                        phase     <= PH_OPEN;
                        kind      <= WK_UNDEC;
                        first_bit <= 1'b0;
                        iv_start  <= now;
                        iv_so     <= s_so;
                    end
                end
                default: begin
                    if (!s_cs) begin
                        // Window closes.
                        phase <= PH_IDLE;
                        if (kind == WK_XFER) begin
                            if (!s_sk) begin
                                o_start <= b_start;
                                o_end   <= now;
                                o_si    <= b_si;
                                o_so    <= b_so;
                                if (first_bit) begin
                                    o_sok  <= b_si;
                                    o_serr <= ~b_si;
                                end else begin
                                    o_bit <= 1'b1;
                                end
                            end
                        end else begin
                            o_start <= iv_start;
                            o_end   <= now;
                            o_si    <= 1'b0;
                            o_so    <= iv_so;
                            o_ready <= iv_so;
                            o_busy  <= ~iv_so;
                        end
                    end else if (kind == WK_XFER) begin
                        if (sk_rise) begin
                            // The previous bit ends; a new one opens.
                            o_start <= b_start;
                            o_end   <= now;
                            o_si    <= b_si;
                            o_so    <= b_so;
                            if (first_bit) begin
                                o_sok  <= b_si;
                                o_serr <= ~b_si;
                            end else begin
                                o_bit <= 1'b1;
                            end
                            first_bit <= 1'b0;
                            b_start   <= now;
                            b_si      <= s_si;
                            b_so      <= 1'b0;
                        end else if (sk_fall) begin
                            b_so <= s_so;
                            if (first_bit && !s_si) b_si <= 1'b0;
                        end
                    end else if (kind == WK_UNDEC && sk_rise && s_si) begin
                        // First rising edge with data-in high: transfer.
                        kind      <= WK_XFER;
                        first_bit <= 1'b1;
                        b_start   <= now;
                        b_si      <= 1'b1;
                        b_so      <= 1'b0;
                    end else begin
                        if (kind == WK_UNDEC && sk_rise) kind <= WK_POLL;
                        if (s_so != iv_so) begin
                            if (!iv_so) begin
                                o_busy  <= 1'b1;
                                o_start <= iv_start;
                                o_end   <= now;
                                o_si    <= 1'b0;
                                o_so    <= 1'b0;
                            end
                            iv_start <= now;
                            iv_so    <= s_so;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mw_monitor.sv
`timescale 1ns/1ps
// mw_monitor: passive monitor for a three-wire serial link. It synchronizes
// the lines, detects clock edges, stamps events and classifies each
// chip-select window as a transfer or a status poll.
// Assumes the serial clock half period is at least two system clocks.
module mw_monitor #(
    parameter int STAMP_W     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_in,
    input  logic               sk_in,
    input  logic               si_in,
    input  logic               so_in,
    output logic               bit_valid,
    output logic               start_ok,
    output logic               start_err,
    output logic               busy_done,
    output logic               ready_done,
    output logic               ev_si,
    output logic               ev_so,
    output logic [STAMP_W-1:0] ev_start,
    output logic [STAMP_W-1:0] ev_end
);
    import mw_pkg::*;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] s_lines;
    logic               fill_ok;
    logic               sk_rise;
    logic               sk_fall;
    logic [STAMP_W-1:0] now;

    assign raw_lines[LN_CS] = cs_in;
    assign raw_lines[LN_SK] = sk_in;
    assign raw_lines[LN_SI] = si_in;
    assign raw_lines[LN_SO] = so_in;

    mw_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (raw_lines),
        .synced  (s_lines),
        .fill_ok (fill_ok)
    );

    mw_edge u_sk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (s_lines[LN_SK]),
        .rise  (sk_rise),
        .fall  (sk_fall)
    );

    mw_stamp #(.W(STAMP_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .count (now)
    );

    mw_core #(.W(STAMP_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill_ok (fill_ok),
        .s_cs    (s_lines[LN_CS]),
        .s_sk    (s_lines[LN_SK]),
        .s_si    (s_lines[LN_SI]),
        .s_so    (s_lines[LN_SO]),
        .sk_rise (sk_rise),
        .sk_fall (sk_fall),
        .now     (now),
        .o_bit   (bit_valid),
        .o_sok   (start_ok),
        .o_serr  (start_err),
        .o_busy  (busy_done),
        .o_ready (ready_done),
        .o_si    (ev_si),
        .o_so    (ev_so),
        .o_start (ev_start),
        .o_end   (ev_end)
    );
endmodule

// File: rtl/mw_monitor_chk.sv
`timescale 1ns/1ps
// mw_monitor_chk: property checker for mw_monitor, attached by bind.
// It observes the ports only.
module mw_monitor_chk #(
    parameter int STAMP_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bit_valid,
    input logic               start_ok,
    input logic               start_err,
    input logic               busy_done,
    input logic               ready_done,
    input logic               ev_si,
    input logic [STAMP_W-1:0] ev_start,
    input logic [STAMP_W-1:0] ev_end
);
    logic               chain_seen;
    logic [STAMP_W-1:0] chain_end;

    // Remember where the last start or data event ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_seen <= 1'b0;
            chain_end  <= '0;
        end else if (bit_valid || start_ok || start_err) begin
            chain_seen <= 1'b1;
            chain_end  <= ev_end;
        end
    end

    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bit_valid, start_ok, start_err, busy_done, ready_done}));

    // R9
    nonzero_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid || start_ok || start_err || busy_done || ready_done)
        |-> (ev_end != ev_start));

    // R9
    bit_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> (chain_seen && ev_start == chain_end));

    // R3
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> ev_si);

    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> !ev_si);
endmodule

bind mw_monitor mw_monitor_chk #(.STAMP_W(STAMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .start_ok   (start_ok),
    .start_err  (start_err),
    .busy_done  (busy_done),
    .ready_done (ready_done),
    .ev_si      (ev_si),
    .ev_start   (ev_start),
    .ev_end     (ev_end)
);

// File: tb/mw_monitor_bench.sv
`timescale 1ns/1ps
// mw_monitor_bench: self-checking bench. Events are logged at the falling
// clock edge and compared with the values expected from the requirements.
module mw_monitor_bench;
    localparam int W = 32;
    // Event type codes used in the log.
    localparam int T_BIT = 1, T_SOK = 2, T_SERR = 3, T_BUSY = 4, T_RDY = 5, T_MULTI = 9;
    // Transfer table: data bit count, data-in bits, data-out bits, half period.
    localparam int NV = 4;
    localparam int        TV_N  [NV] = '{4, 8, 1, 3};
    localparam bit [7:0]  TV_SI [NV] = '{8'b1010, 8'hA5, 8'b1, 8'b011};
    localparam bit [7:0]  TV_SO [NV] = '{8'b0110, 8'h3C, 8'b0, 8'b101};
    localparam int        TV_H  [NV] = '{2, 3, 4, 5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, si = 1'b0, so = 1'b0;
    logic bit_valid, start_ok, start_err, busy_done, ready_done, ev_si, ev_so;
    logic [W-1:0] ev_start, ev_end;

    int total = 0;
    int bad = 0;
    int nev = 0;
    int lg_t [64];
    int lg_si [64];
    int lg_so [64];
    int lg_d [64];

    always #2.5 clk = ~clk;

    mw_monitor u_mw_monitor (
        .clk(clk), .rst_n(rst_n), .cs_in(cs), .sk_in(sk), .si_in(si), .so_in(so),
        .bit_valid(bit_valid), .start_ok(start_ok), .start_err(start_err),
        .busy_done(busy_done), .ready_done(ready_done), .ev_si(ev_si), .ev_so(ev_so),
        .ev_start(ev_start), .ev_end(ev_end)
    );

    // Log every strobe away from the active edge.
    always @(negedge clk) begin
        int n;
        int t;
        n = int'(bit_valid) + int'(start_ok) + int'(start_err) + int'(busy_done) + int'(ready_done);
        if (n != 0 && nev < 64) begin
            t = (n > 1) ? T_MULTI : bit_valid ? T_BIT : start_ok ? T_SOK :
                start_err ? T_SERR : busy_done ? T_BUSY : T_RDY;
            lg_t[nev]  = t;
            lg_si[nev] = int'(ev_si);
            lg_so[nev] = int'(ev_so);
            lg_d[nev]  = int'(ev_end - ev_start);
            nev++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_count(input string tag, input int exp);
        total++;
        if (nev != exp) begin
            bad++;
            $display("FAIL %s event count actual=%0d expected=%0d", tag, nev, exp);
        end
    endtask

    // Compare one logged event; si/so of -1 are not compared.
    task automatic chk_ev(input string tag, input int i, input int t, input int esi,
                          input int eso, input int d);
        total++;
        if (i >= nev || lg_t[i] != t || lg_d[i] != d ||
            (esi >= 0 && lg_si[i] != esi) || (eso >= 0 && lg_so[i] != eso)) begin
            bad++;
            if (i >= nev)
                $display("FAIL %s event %0d missing, expected type=%0d dur=%0d", tag, i, t, d);
            else
                $display("FAIL %s event %0d actual type=%0d si=%0d so=%0d dur=%0d expected type=%0d si=%0d so=%0d dur=%0d",
                         tag, i, lg_t[i], lg_si[i], lg_so[i], lg_d[i], t, esi, eso, d);
        end
    endtask

    // One transfer: start bit, then n data bits MSB first, closed with clock low.
    task automatic xfer(input int n, input bit [7:0] sib, input bit [7:0] sob, input int h);
        cs = 1'b1; sk = 1'b0; si = 1'b0; so = 1'b0;
        step(h);
        for (int i = 0; i <= n; i++) begin
            step(1);
            si = (i == 0) ? 1'b1 : sib[n - i];
            so = (i == 0) ? 1'b0 : sob[n - i];
            step(h - 1);
            sk = 1'b1;
            step(h);
            sk = 1'b0;
        end
        step(h);
        cs = 1'b0;
        step(1);
        si = 1'b0; so = 1'b0;
        step(8);
    endtask

    initial begin
        int h;
        // Reset with chip select already high.
        cs = 1'b1;
        step(4);
        rst_n = 1'b1;
        step(1);
        total++;
        if ({bit_valid, start_ok, start_err, busy_done, ready_done} != 5'b0 || ev_start != 0) begin
            bad++;
            $display("FAIL R1 reset outputs actual=%b expected=00000",
                     {bit_valid, start_ok, start_err, busy_done, ready_done});
        end
        // R1: a window open across reset release is ignored.
        si = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(3); sk = 1'b1; step(3); sk = 1'b0;
        end
        step(3);
        cs = 1'b0; si = 1'b0;
        step(8);
        chk_count("R1 window open at reset", 0);

        // R2 R3 R8 R10: table of transfers.
        for (int v = 0; v < NV; v++) begin
            nev = 0;
            h = TV_H[v];
            xfer(TV_N[v], TV_SI[v], TV_SO[v], h);
            chk_count("R10 transfer table", TV_N[v] + 1);
            chk_ev("R3 start bit", 0, T_SOK, 1, -1, 2 * h);
            for (int k = 1; k <= TV_N[v]; k++)
                chk_ev((k == TV_N[v]) ? "R8 closing bit" : "R2 data bit", k, T_BIT,
                       int'(TV_SI[v][TV_N[v] - k]), int'(TV_SO[v][TV_N[v] - k]), 2 * h);
        end

        // R4: data-in drops between the first rising and falling clock edges.
        nev = 0;
        cs = 1'b1; step(3);
        si = 1'b1; step(2);
        sk = 1'b1; step(1);
        si = 1'b0; step(1);
        sk = 1'b0; step(1);
        si = 1'b1; so = 1'b1; step(1);
        sk = 1'b1; step(2);
        sk = 1'b0; step(2);
        cs = 1'b0; step(1);
        si = 1'b0; so = 1'b0; step(8);
        chk_count("R4 start error", 2);
        chk_ev("R4 start error", 0, T_SERR, 0, -1, 4);
        chk_ev("R4 bit after start error", 1, T_BIT, 1, 1, 4);

        // R8: chip select drops with the clock high, so the open bit is dropped.
        nev = 0;
        cs = 1'b1; step(3);
        si = 1'b1; step(2);
        sk = 1'b1; step(2);
        sk = 1'b0; step(1);
        si = 1'b0; step(1);
        sk = 1'b1; step(2);
        cs = 1'b0; step(2);
        sk = 1'b0; step(8);
        chk_count("R8 close with clock high", 1);
        chk_ev("R8 close with clock high", 0, T_SOK, 1, -1, 4);

        // R5 R7: poll without clock, ending busy.
        nev = 0;
        so = 1'b0; cs = 1'b1; step(10);
        so = 1'b1; step(8);
        so = 1'b0; step(5);
        cs = 1'b0; step(8);
        chk_count("R7 poll busy end", 2);
        chk_ev("R7 busy interval", 0, T_BUSY, -1, -1, 10);
        chk_ev("R5 final busy", 1, T_BUSY, -1, -1, 5);

        // R5: poll without clock, ending ready after a short low stretch.
        nev = 0;
        so = 1'b0; cs = 1'b1; step(3);
        so = 1'b1; step(7);
        cs = 1'b0; step(1);
        so = 1'b0; step(8);
        chk_count("R5 poll ready end", 2);
        chk_ev("R7 leading busy", 0, T_BUSY, -1, -1, 3);
        chk_ev("R5 final ready", 1, T_RDY, -1, -1, 7);

        // R6: a clock edge with data-in low makes a poll.
        nev = 0;
        so = 1'b1; si = 1'b0; cs = 1'b1; step(4);
        sk = 1'b1; step(2);
        sk = 1'b0; step(2);
        so = 1'b0; step(4);
        so = 1'b1; step(3);
        cs = 1'b0; step(1);
        so = 1'b0; step(8);
        chk_count("R6 clocked poll", 2);
        chk_ev("R6 clocked poll busy", 0, T_BUSY, -1, -1, 4);
        chk_ev("R6 clocked poll ready", 1, T_RDY, -1, -1, 3);

        // R1: a transfer still decodes after the ignored windows.
        nev = 0;
        xfer(2, 8'b10, 8'b01, 2);
        chk_count("R1 later transfer", 3);
        chk_ev("R2 later bit", 1, T_BIT, 1, 0, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #500000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule